// File: doc/BRIEF.md
# SDRAM refresh and power-down sequencer

This block is the part of an SDRAM controller that owns the low-power and refresh command slots. It drives the row strobe, column strobe and write enable (all active low), the clock enable and the all-banks select address bit. It answers three kinds of request:

- a periodic refresh pulse,
- a self-refresh level,
- a power-down level.

A request is only acted on while the controller's "all banks idle" input says no row is open. If that input is low, the block first issues precharge-all and waits the precharge time. It then carries out one of the following:

- an auto refresh followed by the row-cycle recovery time;
- self-refresh entry, hold and exit, followed by the same recovery time;
- power-down entry, hold and exit, each transition taking one clock.

A single state machine serves all three flows. The recovery rules are therefore enforced in one place. Power down does not refresh the memory, so the block counts how long the clock enable has been low in power down. Once that count reaches the refresh period, it leaves power down on its own and queues an auto refresh.

The row-cycle time, precharge time and maximum power-down residency are parameters counted in clock cycles, with `T_RP` and `T_RC` at least 2 and `T_REF` at least 2. A busy output tells the rest of the controller to keep its own commands off the bus.

Top module: `sdram_lp_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cke` is 1, `ras_n`/`cas_n`/`we_n` are all 1 (NOP), `all_bank_sel` is 0 and `busy` is 0, whatever the request inputs do.
- R2: Command encodings on {`ras_n`,`cas_n`,`we_n`}:
  - auto refresh is 0,0,1 with `cke` 1, and the clock enable was also 1 on the cycle before;
  - NOP is 1,1,1;
  - `all_bank_sel` is 1 only with precharge-all.
- R3: When a request is taken while `banks_idle` is 0, the block first issues precharge-all (0,1,0 with `all_bank_sel` 1). It then drives NOP and issues the requested command exactly `T_RP` cycles after the precharge. When `banks_idle` is 1, no precharge is issued.
- R4: After an auto refresh the block drives NOP with `busy` high for the next `T_RC-1` cycles. Two auto refreshes are never closer than `T_RC` cycles; a refresh requested during that window is issued `T_RC+1` cycles after the previous one.
- R5: Self-refresh entry is 0,0,1 with `cke` 0 on the same cycle. After it, `cke` stays 0 and the strobes stay NOP for as long as `selfref_req` is 1.
- R6: Self-refresh exit starts the cycle after `selfref_req` is seen low in self refresh. `cke` returns to 1 with NOP, and `busy` stays high for `T_RC` cycles counted from that exit cycle, with no command issued.
- R7: Power-down entry drives `cke` 0 with NOP. When `pwrdn_req` is seen low, the next cycle drives `cke` 1 with NOP and `busy` high (the exit delay), and `busy` falls one cycle later.
- R8: In power down `cke` is never low for more than `T_REF` consecutive cycles. On reaching that limit the block exits as in R7, then issues an auto refresh two cycles after the exit cycle.
- R9: A refresh pulse received during power down causes a power-down exit, followed by an auto refresh two cycles after the exit cycle.
- R10: Priority when several requests are pending in the same idle cycle: refresh first, then self refresh, then power down.
- R11: `busy` is 1 from the first command of a sequence through the last recovery or exit-delay cycle, and 0 in idle. Every non-NOP command and every cycle with `cke` low falls inside a busy interval.
- R12: A request level is answered by a command one cycle after the clock edge that first samples it. A refresh pulse is answered one cycle later, because it is first latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_req | input | 1 | One-cycle pulse asking for an auto refresh |
| selfref_req | input | 1 | Level: stay in self refresh while high |
| pwrdn_req | input | 1 | Level: stay in power down while high |
| banks_idle | input | 1 | High when every bank is precharged and the precharge time has elapsed |
| cke | output | 1 | Clock enable to the memory (registered) |
| ras_n | output | 1 | Row strobe, active low (registered) |
| cas_n | output | 1 | Column strobe, active low (registered) |
| we_n | output | 1 | Write enable, active low (registered) |
| all_bank_sel | output | 1 | Address bit selecting all banks for precharge (registered) |
| busy | output | 1 | Sequencer owns the command bus (registered) |

## Verification
The bench builds the block with `T_RP`=3, `T_RC`=5 and `T_REF`=12. These keep the precharge wait, the row-cycle recovery and the power-down limit distinct from each other, so an off-by-one in any one of them moves a different sample. A residency limit of 12 cycles lets the forced power-down exit, the refresh that follows it and the automatic re-entry all occur within a 30-cycle capture window. The short row-cycle time lets the bench see a refresh requested during recovery issued at exactly `T_RC+1` cycles after the previous one.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_AREF,
    ST_WAIT_RC,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT,
    ST_PD_ENTER,
    ST_PD_HOLD,
    ST_PD_EXIT
  } lp_state_e;

  typedef struct packed {
    logic cke;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic sel;
  } lp_pins_t;

  localparam lp_pins_t PINS_NOP    = '{cke: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, sel: 1'b0};
  localparam lp_pins_t PINS_LOWNOP = '{cke: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, sel: 1'b0};
  localparam lp_pins_t PINS_PREALL = '{cke: 1'b1, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, sel: 1'b1};
  localparam lp_pins_t PINS_AREF   = '{cke: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, sel: 1'b0};
  localparam lp_pins_t PINS_SRENT  = '{cke: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, sel: 1'b0};

  // Pin pattern driven while the sequencer sits in a given state.
  function automatic lp_pins_t pins_for(lp_state_e s);
    case (s)
      ST_PRE:      return PINS_PREALL;
      ST_AREF:     return PINS_AREF;
      ST_SR_ENTER: return PINS_SRENT;
      ST_SR_HOLD,
      ST_PD_ENTER,
      ST_PD_HOLD:  return PINS_LOWNOP;
      default:     return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/lp_delay_timer.sv
// Down-counter shared by the precharge wait and the row-cycle recovery wait.
module lp_delay_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lp_pd_residency.sv
// Counts clock-enable-low cycles spent in power down, saturating at LIMIT.
module lp_pd_residency #(
  parameter int LIMIT = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (start)              cnt_q <= CW'(1);
    else if (run && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LIM);
endmodule

// File: rtl/lp_pin_driver.sv
// Registers the memory-facing pins from the next state so every output is a flop.
module lp_pin_driver
  import sdram_lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lp_state_e state_nxt,
  output logic      cke,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n,
  output logic      sel,
  output logic      busy
);
  lp_pins_t pins_q;
  logic     busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PINS_NOP;
      busy_q <= 1'b0;
    end else begin
      pins_q <= pins_for(state_nxt);
      busy_q <= (state_nxt != ST_IDLE);
    end
  end

  assign cke   = pins_q.cke;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
  assign sel   = pins_q.sel;
  assign busy  = busy_q;
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_REF = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_req,
  input  logic selfref_req,
  input  logic pwrdn_req,
  input  logic banks_idle,
  output logic cke,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic all_bank_sel,
  output logic busy
);
  localparam int TMAX = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RP_LOAD = TW'(T_RP - 2);
  localparam logic [TW-1:0] RC_LOAD = TW'(T_RC - 2);

  lp_state_e    state_q, state_d;
  logic         ref_pend_q, ref_pend_d;
  logic         tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic         res_hit, forced_exit;
  lp_state_e    goal;

  // Highest-priority pending work: refresh, then self refresh, then power down.
  always_comb begin
    if (ref_pend_q)       goal = ST_AREF;
    else if (selfref_req) goal = ST_SR_ENTER;
    else if (pwrdn_req)   goal = ST_PD_ENTER;
    else                  goal = ST_IDLE;
  end

  assign forced_exit = (state_q == ST_PD_HOLD) && res_hit;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = RC_LOAD;
    case (state_q)
      ST_IDLE:     if (goal != ST_IDLE) state_d = banks_idle ? goal : ST_PRE;
      ST_PRE: begin
        state_d  = ST_WAIT_RP;
        tmr_load = 1'b1;
        tmr_val  = RP_LOAD;
      end
      ST_WAIT_RP:  if (tmr_zero) state_d = goal;
      ST_AREF: begin
        state_d  = ST_WAIT_RC;
        tmr_load = 1'b1;
      end
      ST_WAIT_RC:  if (tmr_zero) state_d = ST_IDLE;
      ST_SR_ENTER: state_d = ST_SR_HOLD;
      ST_SR_HOLD:  if (!selfref_req) state_d = ST_SR_EXIT;
      ST_SR_EXIT: begin
        state_d  = ST_WAIT_RC;
        tmr_load = 1'b1;
      end
      ST_PD_ENTER: state_d = ST_PD_HOLD;
      ST_PD_HOLD:  if (!pwrdn_req || ref_pend_q || res_hit) state_d = ST_PD_EXIT;
      ST_PD_EXIT:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // A refresh stays pending until issued; hitting the residency limit adds one.
  assign ref_pend_d = refresh_req | forced_exit | (ref_pend_q & (state_d != ST_AREF));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ref_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_pend_q <= ref_pend_d;
    end
  end

  lp_delay_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  lp_pd_residency #(.LIMIT(T_REF)) u_res (
    .clk      (clk),
    .rst      (rst),
    .start    ((state_d == ST_PD_ENTER) && (state_q != ST_PD_ENTER)),
    .run      ((state_q == ST_PD_ENTER) || (state_q == ST_PD_HOLD)),
    .at_limit (res_hit)
  );

  lp_pin_driver u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_d),
    .cke       (cke),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .sel       (all_bank_sel),
    .busy      (busy)
  );
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk #(
  parameter int T_RC  = 9,
  parameter int T_REF = 1560
) (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic all_bank_sel,
  input logic busy
);
  localparam int GW = $clog2(T_RC + 2);
  localparam int LW = $clog2(T_REF + 2);
  localparam logic [GW-1:0] GSAT = GW'(T_RC + 1);
  localparam logic [LW-1:0] LSAT = LW'(T_REF + 1);

  logic nop_now, aref_now, srent_now, pre_now;
  assign nop_now   = ras_n & cas_n & we_n;
  assign aref_now  = cke & ~ras_n & ~cas_n & we_n;
  assign srent_now = ~cke & ~ras_n & ~cas_n & we_n;
  assign pre_now   = ~ras_n & cas_n & ~we_n;

  logic          in_sr_q;
  logic [GW-1:0] gap_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sr_q <= 1'b0;
      gap_q   <= GSAT;
      low_q   <= '0;
    end else begin
      if (srent_now)   in_sr_q <= 1'b1;
      else if (cke)    in_sr_q <= 1'b0;
      if (aref_now || (cke && in_sr_q)) gap_q <= GW'(1);
      else if (gap_q != GSAT)           gap_q <= gap_q + 1'b1;
      if (cke || srent_now || in_sr_q)  low_q <= '0;
      else if (low_q != LSAT)           low_q <= low_q + 1'b1;
    end
  end

  // R1: idle pins on the first cycle out of reset
  p_reset_idle_r1: assert property (@(posedge clk) $fell(rst) |-> (nop_now && cke && !busy));
  p_aref_cke_r2:   assert property (@(posedge clk) disable iff (rst) aref_now |-> $past(cke));
  p_pre_sel_r3:    assert property (@(posedge clk) disable iff (rst) pre_now |-> all_bank_sel);
  p_rc_gap_r4:     assert property (@(posedge clk) disable iff (rst) !nop_now |-> gap_q >= GW'(T_RC));
  p_low_nop_r5:    assert property (@(posedge clk) disable iff (rst) (!cke && $past(!cke)) |-> nop_now);
  p_exit_nop_r6:   assert property (@(posedge clk) disable iff (rst) $rose(cke) |-> (nop_now && busy));
  p_residency_r8:  assert property (@(posedge clk) disable iff (rst) low_q <= LW'(T_REF));
  p_busy_cover_r11: assert property (@(posedge clk) disable iff (rst) (!nop_now || !cke) |-> busy);
endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.T_RC(T_RC), .T_REF(T_REF)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cke          (cke),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .all_bank_sel (all_bank_sel),
  .busy         (busy)
);

// File: tb/sim_sdram_lp_seq.sv
`timescale 1ns/100ps
module sim_sdram_lp_seq;
  localparam int T_RP = 3;
  localparam int T_RC = 5;
  localparam int T_REF = 12;
  localparam int NW = 48;

  // Pin vectors as {cke, ras_n, cas_n, we_n, all_bank_sel}
  localparam logic [4:0] P_NOP    = 5'b11110;
  localparam logic [4:0] P_LOWNOP = 5'b01110;
  localparam logic [4:0] P_PRE    = 5'b10101;
  localparam logic [4:0] P_AREF   = 5'b10010;
  localparam logic [4:0] P_SREN   = 5'b00010;

  // Row: op(0 refresh,1 self refresh,2 power down), banks_idle, hold, first busy, target, exit, busy fall
  localparam int VEC [6][7] = '{
    '{0, 1, 0,  2, 2,        0,  2 + T_RC},
    '{0, 0, 0,  2, 2 + T_RP, 0,  2 + T_RP + T_RC},
    '{1, 1, 8,  1, 1,        9,  9 + T_RC},
    '{1, 0, 10, 1, 1 + T_RP, 11, 11 + T_RC},
    '{2, 1, 6,  1, 1,        7,  8},
    '{2, 0, 8,  1, 1 + T_RP, 9,  10}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic refresh_req = 1'b0, selfref_req = 1'b0, pwrdn_req = 1'b0, banks_idle = 1'b1;
  logic cke, ras_n, cas_n, we_n, all_bank_sel, busy;

  int  errs = 0, checks = 0;
  bit  finished = 1'b0;
  logic [4:0] smp [NW];
  logic       bsy [NW];
  bit s_ref [NW], s_sr [NW], s_pd [NW];

  always #2.5 clk = ~clk;

  sdram_lp_seq #(.T_RP(T_RP), .T_RC(T_RC), .T_REF(T_REF)) u0 (
    .clk(clk), .rst(rst), .refresh_req(refresh_req), .selfref_req(selfref_req),
    .pwrdn_req(pwrdn_req), .banks_idle(banks_idle), .cke(cke), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .all_bank_sel(all_bank_sel), .busy(busy)
  );

  task automatic chk_pin(input int i, input logic [4:0] exp, input string tag);
    checks++;
    if (smp[i] !== exp) begin
      errs++;
      $display("FAIL %s sample %0d pins=%b expected %b", tag, i, smp[i], exp);
    end
  endtask

  task automatic chk_busy(input int i, input logic exp, input string tag);
    checks++;
    if (bsy[i] !== exp) begin
      errs++;
      $display("FAIL %s sample %0d busy=%b expected %b", tag, i, bsy[i], exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NW; i++) begin
      s_ref[i] = 1'b0; s_sr[i] = 1'b0; s_pd[i] = 1'b0;
    end
  endtask

  // Sample at each falling edge, then drive the inputs for the next rising edge.
  task automatic play(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp[i] = {cke, ras_n, cas_n, we_n, all_bank_sel};
      bsy[i] = busy;
      refresh_req = s_ref[i];
      selfref_req = s_sr[i];
      pwrdn_req   = s_pd[i];
    end
    refresh_req = 1'b0; selfref_req = 1'b0; pwrdn_req = 1'b0;
  endtask

  task automatic settle();
    repeat (T_RC + T_RP + 6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R11 watchdog expired: busy=%b expected sequence end", busy);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds idle pins even with requests present
    pwrdn_req = 1'b1; refresh_req = 1'b1;
    repeat (3) @(negedge clk);
    smp[0] = {cke, ras_n, cas_n, we_n, all_bank_sel}; bsy[0] = busy;
    chk_pin(0, P_NOP, "R1"); chk_busy(0, 1'b0, "R1");
    rst = 1'b0; pwrdn_req = 1'b0; refresh_req = 1'b0;
    @(negedge clk);
    smp[0] = {cke, ras_n, cas_n, we_n, all_bank_sel}; bsy[0] = busy;
    chk_pin(0, P_NOP, "R1"); chk_busy(0, 1'b0, "R1");
    settle();

    // Table of flows
    for (int r = 0; r < 6; r++) begin
      int op, idl, hold, t0, tgt, ex, fall;
      logic [4:0] tp, ep;
      logic eb;
      string tag;
      op = VEC[r][0]; idl = VEC[r][1]; hold = VEC[r][2]; t0 = VEC[r][3];
      tgt = VEC[r][4]; ex = VEC[r][5]; fall = VEC[r][6];
      tp = (op == 0) ? P_AREF : (op == 1) ? P_SREN : P_LOWNOP;
      clear_stim();
      banks_idle = idl[0];
      for (int i = 0; i < NW; i++) begin
        s_ref[i] = (op == 0) && (i == 0);
        s_sr[i]  = (op == 1) && (i < hold);
        s_pd[i]  = (op == 2) && (i < hold);
      end
      play(24);
      for (int i = 0; i < 24; i++) begin
        if (i < t0) begin ep = P_NOP; eb = 1'b0; tag = "R12"; end
        else if (i == t0 && idl == 0) begin ep = P_PRE; eb = 1'b1; tag = "R3"; end
        else if (i < tgt) begin ep = P_NOP; eb = 1'b1; tag = "R3"; end
        else if (i == tgt) begin
          ep = tp; eb = 1'b1; tag = (op == 0) ? "R2" : (op == 1) ? "R5" : "R7";
        end
        else if (op != 0 && i < ex) begin ep = P_LOWNOP; eb = 1'b1; tag = (op == 1) ? "R5" : "R7"; end
        else if (op != 0 && i == ex) begin ep = P_NOP; eb = 1'b1; tag = (op == 1) ? "R6" : "R7"; end
        else if (i < fall) begin ep = P_NOP; eb = 1'b1; tag = (op == 0) ? "R4" : "R6"; end
        else begin ep = P_NOP; eb = 1'b0; tag = "R11"; end
        chk_pin(i, ep, tag);
        chk_busy(i, eb, tag);
      end
      banks_idle = 1'b1;
      settle();
    end

    // R8: power down held past the residency limit
    clear_stim();
    for (int i = 0; i < 40; i++) s_pd[i] = 1'b1;
    play(30);
    for (int i = 1; i <= T_REF; i++) chk_pin(i, P_LOWNOP, "R8");
    chk_pin(1 + T_REF, P_NOP, "R8");
    chk_busy(1 + T_REF, 1'b1, "R8");
    chk_pin(3 + T_REF, P_AREF, "R8");
    chk_pin(4 + T_REF + T_RC, P_LOWNOP, "R8");
    settle();

    // R9: refresh pulse during power down
    clear_stim();
    for (int i = 0; i < 30; i++) s_pd[i] = 1'b1;
    s_ref[4] = 1'b1;
    play(16);
    chk_pin(5, P_LOWNOP, "R9");
    chk_pin(6, P_NOP, "R9");
    chk_pin(8, P_AREF, "R9");
    settle();

    // R10: refresh before self refresh
    clear_stim();
    s_ref[0] = 1'b1;
    for (int i = 1; i < 20; i++) s_sr[i] = 1'b1;
    play(24);
    chk_pin(2, P_AREF, "R10");
    chk_busy(2 + T_RC, 1'b0, "R10");
    chk_pin(3 + T_RC, P_SREN, "R10");
    settle();

    // R10: self refresh before power down
    clear_stim();
    for (int i = 0; i < 6; i++) begin s_sr[i] = 1'b1; s_pd[i] = 1'b1; end
    play(8);
    chk_pin(1, P_SREN, "R10");
    settle();

    // R4: second refresh requested during recovery
    clear_stim();
    s_ref[0] = 1'b1; s_ref[3] = 1'b1;
    play(12);
    chk_pin(2, P_AREF, "R4");
    for (int i = 3; i < 3 + T_RC; i++) chk_pin(i, P_NOP, "R4");
    chk_pin(3 + T_RC, P_AREF, "R4");
    settle();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule